// File: doc/BRIEF.md
# Multi-Valued CAM Digit-Serial Search

This block is a word-parallel content-addressable memory that holds `WORDS` stored words of `WIDTH` bits in registers. A search takes a reference word and compares it against every stored word at the same time. It examines one 2-bit digit per clock, starting with the most significant digit. A full search therefore takes `WIDTH/2` cycles, whatever the number of words. `WIDTH` must be even.

Each word owns a pair of flags, `flagHi` and `flagLo`. Together they report whether the reference is equal to, below or above the stored value. The first digit that differs decides the outcome, and the flags stay frozen for the rest of that search. A one-cycle `done` strobe marks the point where the result is final. The result then holds until the next search starts.

Writes are accepted at any time. If a write arrives while a search is running, or in the cycle that starts one, it is parked in a single pending slot. The slot is committed once the search is over, so every search sees the contents exactly as they were when it began.

Top module: `mvcam_top`

## Requirements
- R1: After reset, `busy` and `done` are 0, every `flagHi` bit is 0, every `flagLo` bit is 1 (equal code), `matchVec` is all ones, and every stored word is zero.
- R2: A write (`wrEn`=1) in a cycle with `busy`=0 and `srchStart`=0 stores `wrData` into word `wrAddr` at that clock edge.
- R3: `srchStart`=1 with `busy`=0 captures `srchRef` and presets every word's flags to the equal code. `busy` is then 1 for exactly `WIDTH/2` cycles. `srchStart` while `busy`=1 is ignored.
- R4: Digit k is bits [2k+1:2k]. Digits are compared from k=`WIDTH/2`-1 down to 0. Once a word's flags leave the equal code, they stay unchanged until the search ends.
- R5: The flag pair {flagHi,flagLo} is 01 when the reference equals the stored word, 11 when the reference is less than it, and 00 when the reference is greater. 10 never appears.
- R6: `matchVec[i]` is 1 exactly when word i holds the equal code.
- R7: `done` is high for one cycle, in the cycle right after the last digit step, with `busy`=0. The flags then keep the final result until the next accepted start.
- R8: A write that arrives while `busy`=1, or together with an accepted start, is deferred. The running search compares against the contents as they stood at its start. The deferred write is committed at the first clock edge with `busy`=0.
- R9: There is one pending slot. A later deferred write in the same search replaces the earlier one, and the replaced write is never stored.
- R10: Outside a search (`busy`=0 and no start), the flags do not change, even when the stored words are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request |
| wrAddr | input | IDX_W | Word index to write |
| wrData | input | WIDTH | Value to store |
| srchStart | input | 1 | Start a search |
| srchRef | input | WIDTH | Reference word, captured at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search strobe |
| matchVec | output | WORDS | Per-word equality result |
| flagHi | output | WORDS | Per-word upper flag of the result code |
| flagLo | output | WORDS | Per-word lower flag of the result code |

## Verification
A write and a search can fall in the same cycle: a write may coincide with an accepted start, or land on any cycle of a running search. A second deferred write may also arrive before the first one is committed. The bench provokes these cases and judges them in two steps. First, the results of that search must match the contents captured at its start. Second, a follow-up search must show that only the last deferred write reached storage. Around this, every reference value is swept exhaustively against several sets of stored words in a 6-bit, 4-word configuration, and each flag pair is checked against an arithmetic comparison.

// File: rtl/mvcam_pkg.sv
package mvcam_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic preset;     // accepted start: capture reference, preset flags
    logic compare;    // a digit step is in progress this cycle
    logic holdWrite;  // incoming write must be parked
    logic flushPend;  // pending write may be committed
  } camStrobe_t;

  // {hi, lo} result codes
  localparam logic [1:0] CODE_EQ = 2'b01;
  localparam logic [1:0] CODE_LT = 2'b11;  // reference below stored
  localparam logic [1:0] CODE_GT = 2'b00;  // reference above stored

endpackage

// File: rtl/mvcam_ctrl.sv
module mvcam_ctrl
  import mvcam_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter int DIG_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srchStart,
  output camStrobe_t       strobe,
  output logic [DIG_W-1:0] digitSel,
  output logic             busy,
  output logic             done
);

  logic             busyQ;
  logic             doneQ;
  logic [DIG_W-1:0] cntQ;

  always_comb begin
    strobe.preset    = srchStart & ~busyQ;
    strobe.compare   = busyQ;
    strobe.holdWrite = busyQ | (srchStart & ~busyQ);
    strobe.flushPend = ~busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (strobe.preset) begin
        busyQ <= 1'b1;
        cntQ  <= DIG_W'(DIGITS - 1);
      end else if (busyQ) begin
        if (cntQ == '0) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  assign digitSel = cntQ;
  assign busy     = busyQ;
  assign done     = doneQ;

endmodule

// File: rtl/mvcam_datapath.sv
module mvcam_datapath
  import mvcam_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WIDTH  = 16,
  parameter int DIGITS = 8,
  parameter int DIG_W  = 3,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  camStrobe_t       strobe,
  input  logic [DIG_W-1:0] digitSel,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] srchRef,
  output logic [WORDS-1:0] hiVec,
  output logic [WORDS-1:0] loVec
);

  logic [WIDTH-1:0] memQ [WORDS];
  logic             pendValidQ;
  logic [IDX_W-1:0] pendAddrQ;
  logic [WIDTH-1:0] pendDataQ;
  logic [WIDTH-1:0] refQ;
  logic [WORDS-1:0] hiQ;
  logic [WORDS-1:0] loQ;
  logic [1:0]       refDigit;

  function automatic logic [1:0] digitOf(input logic [WIDTH-1:0] v,
                                         input logic [DIG_W-1:0] idx);
    return v[int'(idx)*2 +: 2];
  endfunction

  // Storage: pending commit first, a direct idle write overrides it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) memQ[w] <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (strobe.flushPend && pendValidQ && pendAddrQ == IDX_W'(w))
          memQ[w] <= pendDataQ;
        if (wrEn && !strobe.holdWrite && wrAddr == IDX_W'(w))
          memQ[w] <= wrData;
      end
    end
  end

  // Single pending slot, last deferred write wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValidQ <= 1'b0;
      pendAddrQ  <= '0;
      pendDataQ  <= '0;
    end else if (wrEn && strobe.holdWrite) begin
      pendValidQ <= 1'b1;
      pendAddrQ  <= wrAddr;
      pendDataQ  <= wrData;
    end else if (strobe.flushPend) begin
      pendValidQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              refQ <= '0;
    else if (strobe.preset) refQ <= srchRef;
  end

  assign refDigit = digitOf(refQ, digitSel);

  // Per-word flag pairs; frozen once they leave the equal code
  always_ff @(posedge clk) begin
    if (!rstN || strobe.preset) begin
      hiQ <= '0;
      loQ <= '1;
    end else if (strobe.compare) begin
      for (int w = 0; w < WORDS; w++) begin
        if ({hiQ[w], loQ[w]} == CODE_EQ) begin
          if (refDigit < digitOf(memQ[w], digitSel))      hiQ[w] <= 1'b1;
          else if (refDigit > digitOf(memQ[w], digitSel)) loQ[w] <= 1'b0;
        end
      end
    end
  end

  assign hiVec = hiQ;
  assign loVec = loQ;

endmodule

// File: rtl/mvcam_top.sv
module mvcam_top
  import mvcam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             srchStart,
  input  logic [WIDTH-1:0] srchRef,
  output logic             busy,
  output logic             done,
  output logic [WORDS-1:0] matchVec,
  output logic [WORDS-1:0] flagHi,
  output logic [WORDS-1:0] flagLo
);

  localparam int DIGITS = WIDTH / 2;
  localparam int DIG_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  camStrobe_t       strobe;
  logic [DIG_W-1:0] digitSel;

  mvcam_ctrl #(.DIGITS(DIGITS), .DIG_W(DIG_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .srchStart (srchStart),
    .strobe    (strobe),
    .digitSel  (digitSel),
    .busy      (busy),
    .done      (done)
  );

  mvcam_datapath #(
    .WORDS(WORDS), .WIDTH(WIDTH), .DIGITS(DIGITS), .DIG_W(DIG_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .digitSel (digitSel),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .srchRef  (srchRef),
    .hiVec    (flagHi),
    .loVec    (flagLo)
  );

  assign matchVec = ~flagHi & flagLo;

endmodule

// File: rtl/mvcam_checker.sv
module mvcam_checker #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             srchStart,
  input logic             busy,
  input logic             done,
  input logic [WORDS-1:0] flagHi,
  input logic [WORDS-1:0] flagLo
);

  localparam int DIGITS = WIDTH / 2;
  localparam int CNT_W  = $clog2(DIGITS + 1) + 1;

  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_timing_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && busyCnt == CNT_W'(DIGITS)));

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyCnt < CNT_W'(DIGITS));

  assert_start_preset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (srchStart && !busy) |=> (busy && flagHi == '0 && flagLo == '1));

  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flagHi & ~flagLo) == '0);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !srchStart) |=> ($stable(flagHi) && $stable(flagLo)));

  for (genvar g = 0; g < WORDS; g++) begin : g_frozen
    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
      (busy && (flagHi[g] || !flagLo[g])) |=> ($stable(flagHi[g]) && $stable(flagLo[g])));
  end

endmodule

bind mvcam_top mvcam_checker #(.WORDS(WORDS), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .srchStart (srchStart),
  .busy      (busy),
  .done      (done),
  .flagHi    (flagHi),
  .flagLo    (flagLo)
);

// File: tb/test_mvcam_top.sv
module test_mvcam_top;

  localparam int WORDS  = 4;
  localparam int WIDTH  = 6;
  localparam int DIGITS = WIDTH / 2;
  localparam int IDX_W  = 2;

  logic             clk = 1'b0;
  logic             rstN;
  logic             wrEn;
  logic [IDX_W-1:0] wrAddr;
  logic [WIDTH-1:0] wrData;
  logic             srchStart;
  logic [WIDTH-1:0] srchRef;
  logic             busy, done;
  logic [WORDS-1:0] matchVec, flagHi, flagLo;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] model [WORDS];

  always #5 clk = ~clk;

  mvcam_top #(.WORDS(WORDS), .WIDTH(WIDTH)) i_mvcam_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .srchStart(srchStart), .srchRef(srchRef), .busy(busy), .done(done),
    .matchVec(matchVec), .flagHi(flagHi), .flagLo(flagLo)
  );

  function automatic logic [1:0] expCode(input logic [WIDTH-1:0] r, input logic [WIDTH-1:0] s);
    if (r == s)     return 2'b01;
    else if (r < s) return 2'b11;
    else            return 2'b00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkFlags(input logic [WIDTH-1:0] snap [WORDS],
                            input logic [WIDTH-1:0] r, input string req);
    for (int i = 0; i < WORDS; i++) begin
      logic [1:0] e;
      e = expCode(r, snap[i]);
      check({flagHi[i], flagLo[i]} == e, req, $sformatf("code word %0d ref %0d", i, r),
            {flagHi[i], flagLo[i]}, e);
      check(matchVec[i] == (r == snap[i]), "R6", $sformatf("match word %0d", i),
            matchVec[i], r == snap[i]);
    end
  endtask

  task automatic doWrite(input int a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = IDX_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    model[a] = d;  // R2 idle write
  endtask

  task automatic runSearch(input logic [WIDTH-1:0] r, input string req);
    logic [WIDTH-1:0] snap [WORDS];
    @(negedge clk);
    srchStart = 1'b1; srchRef = r;
    snap = model;
    @(negedge clk);
    srchStart = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R3", "busy after start", busy, 1);
    for (int k = 1; k < DIGITS; k++) begin
      @(negedge clk);
      check(busy == 1'b1 && done == 1'b0, "R3", "busy during search", busy, 1);
    end
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R7", "done after last digit", done, 1);
    checkFlags(snap, r, req);
    @(negedge clk);
    check(done == 1'b0, "R7", "done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] snap [WORDS];
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; srchStart = 1'b0; srchRef = '0;
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(flagHi == '0, "R1", "flagHi", flagHi, 0);
    check(flagLo == '1, "R1", "flagLo", flagLo, 15);
    check(matchVec == '1, "R1", "matchVec", matchVec, 15);
    runSearch('0, "R1");  // storage all zero

    // R4 R5 exhaustive sweep over references for several stored sets
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < WORDS; i++) begin
        logic [WIDTH-1:0] v;
        if (s == 0) v = (i == 0) ? 6'd0 : (i == 1) ? 6'd63 : (i == 2) ? 6'd31 : 6'd32;
        else        v = WIDTH'((s * 17 + i * 23 + s * i * 5) % 64);
        doWrite(i, v);
      end
      for (int r = 0; r < 64; r++) runSearch(WIDTH'(r), "R4_R5");
    end

    // R10: idle writes leave the flags alone
    doWrite(0, 6'd12); doWrite(1, 6'd40); doWrite(2, 6'd12); doWrite(3, 6'd3);
    runSearch(6'd12, "R5");
    snap = model;
    doWrite(0, 6'd50);
    repeat (3) @(negedge clk);
    checkFlags(snap, 6'd12, "R10");
    runSearch(6'd50, "R2");  // the idle write landed

    // R8 R9 R3: writes colliding with a search, ignored restart
    doWrite(0, 6'd10); doWrite(1, 6'd20);
    snap = model;
    @(negedge clk);
    srchStart = 1'b1; srchRef = 6'd20;
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 6'd20;   // deferred, later replaced
    @(negedge clk);
    srchStart = 1'b0;
    wrAddr = 2'd1; wrData = 6'd5;                 // R9 replaces pending slot
    @(negedge clk);
    wrEn = 1'b0;
    srchStart = 1'b1; srchRef = 6'd0;             // R3 ignored while busy
    check(busy == 1'b1, "R3", "busy at second start", busy, 1);
    @(negedge clk);
    srchStart = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R3", "still in search", busy, 1);
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R3", "done timing unchanged", done, 1);
    checkFlags(snap, 6'd20, "R8");
    @(negedge clk);
    check(busy == 1'b0, "R3", "ignored start not queued", busy, 0);
    model[1] = 6'd5;  // only the last deferred write reaches storage
    runSearch(6'd10, "R9");
    runSearch(6'd5, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule